// File: doc/BRIEF.md
# Parallel EEPROM Host Bus Controller

This block sits between an on-chip requester and a byte-wide parallel EEPROM. It turns single read and write requests, taken through a valid/ready command port, into waveforms on the memory's active-low chip enable, output enable and write enable, its address bus and a data bus split into output value, output enable and input value. Every pin timing (access time, bus turnaround, write pulse width, data and address setup and hold, byte-load cycle, byte-load window, programming time and power-up write lockout) is a parameter counted in clock cycles and rounded up from the memory's nanosecond figure.

Writes that arrive back to back are chained into one page load: as soon as the write enable has been high long enough to satisfy the minimum byte-load cycle, a queued write issues the next pulse, well inside the byte-load window. When no write is waiting at that point (the queue is empty or the next request is a read), the controller deliberately lets the window run out, then waits out the internal programming time before it touches the memory again. After reset, writes are held back for a lockout period while reads are still served. A busy flag covers the lockout and the whole end-of-burst wait; stalled requests are held by deasserting ready, never dropped.

Top module: `eep_host_ctrl`

## Requirements
- R1: A read drives chip enable and output enable low and write enable high for exactly T_ACC cycles; the byte on the data input at the end of that time is returned on rd_data with rd_valid high for one cycle.
- R2: After a read, the data output enable stays low for more than T_TURN cycles from the rise of output enable, and it is never high while output enable is low.
- R3: A write holds output enable high, drives chip enable and write enable low, and drives the data output with its enable high for WLOW = max(T_WP, T_AH, T_DS) cycles; address and data do not change during the low pulse.
- R4: When a write request is valid at the moment write enable has been high for HIGH_MIN = max(1, T_BLC_MIN - WLOW) cycles, the next write pulse starts then, so the gap is HIGH_MIN cycles (below T_BLC_MAX) and each byte-load cycle is at least T_BLC_MIN cycles.
- R5: When no write is valid at that moment (nothing pending or a read pending), no pin access starts until at least T_BLC_MAX + T_WC cycles after the last write enable rise.
- R6: No write pulse starts during the first T_INIT cycles after reset; a write offered then sees cmd_ready low and is performed later; reads are served during the lockout.
- R7: busy is high during the power-up lockout and from the end of a write burst until the programming wait has passed; a write request is never accepted while busy is high; busy is low when the controller is idle after both.
- R8: Every accepted write reaches the memory: a later read of that address returns the last byte written to it.
- R9: Out of reset, chip enable, output enable and write enable are high, the data output enable is low and rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Command accepted this cycle when valid is also high |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | DATA_W | Write byte |
| busy | output | 1 | Lockout or post-burst programming wait in progress |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read byte |
| ee_ce_n | output | 1 | Memory chip enable, active low |
| ee_oe_n | output | 1 | Memory output enable, active low |
| ee_we_n | output | 1 | Memory write enable, active low |
| ee_addr | output | ADDR_W | Memory address bus |
| ee_dq_o | output | DATA_W | Data bus value driven by the controller |
| ee_dq_oe | output | 1 | Controller drives the data bus when high |
| ee_dq_i | input | DATA_W | Data bus value driven by the memory |

## Verification
The main function is tried with single isolated writes, queued bursts of up to four bytes that must chain, bursts closed by a pending read rather than by an empty queue, and random mixes of reads and bursts over random addresses and data. Chained and unchained bursts are told apart by the write-enable high time measured on the pins, which must be exactly the minimum gap in one case and cover the window plus the programming time in the other. Read-after-write patterns separate a lost or misplaced byte from a correct page load, and write-after-read patterns expose a missing bus turnaround. A write offered right after reset shows whether the lockout stalls it rather than drops it.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WLOW,
    ST_WGAP,
    ST_WEND,
    ST_PROG
  } eep_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/eep_lockout.sv
module eep_lockout #(
  parameter int unsigned T_INIT = 2000000
) (
  input  logic clk,
  input  logic rst,
  output logic locked
);
  localparam int unsigned CW = $clog2(T_INIT + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != CW'(T_INIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign locked = (cnt != CW'(T_INIT));

endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_ACC     = 40,
  parameter int unsigned T_TURN    = 10,
  parameter int unsigned WLOW      = 30,
  parameter int unsigned HIGH_MIN  = 1,
  parameter int unsigned T_BLC_MAX = 20000,
  parameter int unsigned T_WC      = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locked,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [DATA_W-1:0] ee_dq_o,
  output logic              ee_dq_oe,
  input  logic [DATA_W-1:0] ee_dq_i
);
  localparam int unsigned CMAX = max3(max3(T_ACC, T_TURN, WLOW), T_BLC_MAX, T_WC);
  localparam int unsigned CW   = $clog2(CMAX + 1);

  eep_state_e    st;
  logic [CW-1:0] cnt;
  logic          take;
  logic          gap_done;

  assign gap_done = (st == ST_WGAP) && (cnt == CW'(HIGH_MIN - 1));

  always_comb begin
    cmd_ready = 1'b0;
    if (st == ST_IDLE)  cmd_ready = !(cmd_we && locked);
    else if (gap_done)  cmd_ready = cmd_we;
  end

  assign take = cmd_valid && cmd_ready;
  assign busy = locked || (st == ST_WEND) || (st == ST_PROG);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ee_ce_n  <= 1'b1;
      ee_oe_n  <= 1'b1;
      ee_we_n  <= 1'b1;
      ee_dq_oe <= 1'b0;
      ee_addr  <= '0;
      ee_dq_o  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      cnt      <= cnt + 1'b1;
      if (take) begin
        cnt     <= '0;
        ee_addr <= cmd_addr;
        ee_ce_n <= 1'b0;
        if (cmd_we) begin
          ee_we_n  <= 1'b0;
          ee_dq_o  <= cmd_wdata;
          ee_dq_oe <= 1'b1;
          st       <= ST_WLOW;
        end else begin
          ee_oe_n <= 1'b0;
          st      <= ST_READ;
        end
      end else begin
        case (st)
          ST_READ: if (cnt == CW'(T_ACC - 1)) begin
            rd_data  <= ee_dq_i;
            rd_valid <= 1'b1;
            ee_ce_n  <= 1'b1;
            ee_oe_n  <= 1'b1;
            cnt      <= '0;
            st       <= ST_TURN;
          end
          ST_TURN: if (cnt == CW'(T_TURN - 1)) st <= ST_IDLE;
          ST_WLOW: if (cnt == CW'(WLOW - 1)) begin
            ee_we_n  <= 1'b1;
            ee_ce_n  <= 1'b1;
            ee_dq_oe <= 1'b0;
            cnt      <= '0;
            st       <= ST_WGAP;
          end
          ST_WGAP: if (gap_done) st <= ST_WEND;
          ST_WEND: if (cnt == CW'(T_BLC_MAX - 1)) begin
            cnt <= '0;
            st  <= ST_PROG;
          end
          ST_PROG: if (cnt == CW'(T_WC - 1)) st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eep_host_ctrl.sv
module eep_host_ctrl
  import eep_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_ACC     = 40,
  parameter int unsigned T_TURN    = 10,
  parameter int unsigned T_WP      = 30,
  parameter int unsigned T_DS      = 10,
  parameter int unsigned T_AH      = 20,
  parameter int unsigned T_BLC_MIN = 30,
  parameter int unsigned T_BLC_MAX = 20000,
  parameter int unsigned T_WC      = 2000000,
  parameter int unsigned T_INIT    = 2000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ee_ce_n,
  output logic              ee_oe_n,
  output logic              ee_we_n,
  output logic [ADDR_W-1:0] ee_addr,
  output logic [DATA_W-1:0] ee_dq_o,
  output logic              ee_dq_oe,
  input  logic [DATA_W-1:0] ee_dq_i
);
  localparam int unsigned WLOW     = max3(T_WP, T_AH, T_DS);
  localparam int unsigned HIGH_MIN = (T_BLC_MIN > WLOW + 1) ? (T_BLC_MIN - WLOW) : 1;

  logic locked;

  eep_lockout #(.T_INIT(T_INIT)) lock_i (
    .clk    (clk),
    .rst    (rst),
    .locked (locked)
  );

  eep_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .T_ACC     (T_ACC),
    .T_TURN    (T_TURN),
    .WLOW      (WLOW),
    .HIGH_MIN  (HIGH_MIN),
    .T_BLC_MAX (T_BLC_MAX),
    .T_WC      (T_WC)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_we    (cmd_we),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ee_ce_n   (ee_ce_n),
    .ee_oe_n   (ee_oe_n),
    .ee_we_n   (ee_we_n),
    .ee_addr   (ee_addr),
    .ee_dq_o   (ee_dq_o),
    .ee_dq_oe  (ee_dq_oe),
    .ee_dq_i   (ee_dq_i)
  );

endmodule

// File: rtl/eep_host_ctrl_chk.sv
module eep_host_ctrl_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_INIT = 2000000
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_we,
  input logic              cmd_ready,
  input logic              busy,
  input logic              rd_valid,
  input logic              ee_ce_n,
  input logic              ee_oe_n,
  input logic              ee_we_n,
  input logic [ADDR_W-1:0] ee_addr,
  input logic [DATA_W-1:0] ee_dq_o,
  input logic              ee_dq_oe
);
  localparam int unsigned CW = $clog2(T_INIT + 2);

  logic [CW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CW'(T_INIT)) since_rst <= since_rst + 1'b1;
  end

  a_r1_read_pins: assert property (@(posedge clk) disable iff (rst)
    !ee_oe_n |-> (ee_we_n && !ee_ce_n));

  a_r2_no_contention: assert property (@(posedge clk) disable iff (rst)
    ee_dq_oe |-> ee_oe_n);

  a_r3_write_pins: assert property (@(posedge clk) disable iff (rst)
    !ee_we_n |-> (ee_oe_n && !ee_ce_n && ee_dq_oe));

  a_r3_stable_pulse: assert property (@(posedge clk) disable iff (rst)
    (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_dq_o)));

  a_r6_lockout: assert property (@(posedge clk) disable iff (rst)
    (since_rst != CW'(T_INIT)) |-> ee_we_n);

  a_r7_busy_stalls: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && cmd_we) |-> !cmd_ready);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

endmodule

bind eep_host_ctrl eep_host_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .T_INIT (T_INIT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_we    (cmd_we),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .ee_ce_n   (ee_ce_n),
  .ee_oe_n   (ee_oe_n),
  .ee_we_n   (ee_we_n),
  .ee_addr   (ee_addr),
  .ee_dq_o   (ee_dq_o),
  .ee_dq_oe  (ee_dq_oe)
);

// File: tb/eep_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module eep_host_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int T_ACC = 40, T_TURN = 10, T_WP = 30, T_DS = 10, T_AH = 20;
  localparam int T_BLC_MIN = 45, T_BLC_MAX = 200, T_WC = 600, T_INIT = 300;
  // expected pulse and gap lengths from R3 and R4
  localparam int EXP_WLOW = 30;
  localparam int EXP_GAP  = 15;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_we = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, busy, rd_valid;
  logic [DW-1:0] rd_data;
  logic ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_dq_o, ee_dq_i;

  logic [DW-1:0] model_mem [256];
  logic [DW-1:0] ref_mem [256];

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  assign ee_dq_i = (!ee_ce_n && !ee_oe_n) ? model_mem[ee_addr] : 8'h00;

  eep_host_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_ACC(T_ACC), .T_TURN(T_TURN), .T_WP(T_WP),
    .T_DS(T_DS), .T_AH(T_AH), .T_BLC_MIN(T_BLC_MIN), .T_BLC_MAX(T_BLC_MAX),
    .T_WC(T_WC), .T_INIT(T_INIT)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n),
    .ee_we_n(ee_we_n), .ee_addr(ee_addr), .ee_dq_o(ee_dq_o), .ee_dq_oe(ee_dq_oe),
    .ee_dq_i(ee_dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- pin monitor ----------------
  int cyc = 0, lo_cnt = 0, lo_last = 0, hi_cnt = 0, rd_lo = 0, since_oe = 0;
  bit p_we = 1, p_oe = 1, p_dqoe = 0, wrote_any = 0, had_read = 0, unstable = 0;
  logic [AW-1:0] lat_a;
  logic [DW-1:0] lat_d;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; p_we = 1; p_oe = 1; p_dqoe = 0;
    end else begin
      cyc++;
      if (!ee_we_n) begin
        if (p_we) begin
          chk(cyc > T_INIT, "R6 write pulse after lockout", cyc, T_INIT + 1);
          chk(!ee_ce_n && ee_oe_n && ee_dq_oe, "R3 write pin levels", {ee_ce_n, ee_oe_n, ee_dq_oe}, 3'b011);
          if (wrote_any) begin
            if (hi_cnt < T_BLC_MAX) begin
              chk(hi_cnt == EXP_GAP, "R4 chained gap", hi_cnt, EXP_GAP);
              chk(lo_last + hi_cnt >= T_BLC_MIN, "R4 byte-load cycle", lo_last + hi_cnt, T_BLC_MIN);
            end else begin
              chk(hi_cnt >= T_BLC_MAX + T_WC, "R5 wait before next write", hi_cnt, T_BLC_MAX + T_WC);
            end
          end
          lo_cnt = 0; unstable = 0; lat_a = ee_addr; lat_d = ee_dq_o;
        end
        lo_cnt++;
        if (ee_addr != lat_a || ee_dq_o != lat_d) unstable = 1;
      end else begin
        if (!p_we) begin
          chk(lo_cnt == EXP_WLOW, "R3 pulse width", lo_cnt, EXP_WLOW);
          chk(!unstable, "R3 address/data stable", unstable, 0);
          model_mem[lat_a] = lat_d;
          wrote_any = 1; hi_cnt = 0; lo_last = lo_cnt;
        end
        hi_cnt++;
      end
      if (!ee_oe_n) begin
        if (p_oe) begin
          chk(ee_we_n && !ee_ce_n, "R1 read pin levels", {ee_we_n, ee_ce_n}, 2'b10);
          if (wrote_any)
            chk(hi_cnt >= T_BLC_MAX + T_WC, "R5 wait before read", hi_cnt, T_BLC_MAX + T_WC);
          rd_lo = 0;
        end
        rd_lo++;
      end else begin
        if (!p_oe) begin
          chk(rd_lo == T_ACC, "R1 access length", rd_lo, T_ACC);
          since_oe = 0; had_read = 1;
        end
        since_oe++;
      end
      if (ee_dq_oe && !p_dqoe && had_read) begin
        chk(since_oe > T_TURN, "R2 bus turnaround", since_oe, T_TURN + 1);
        chk(ee_oe_n, "R2 no drive during read", ee_oe_n, 1);
      end
      p_we = ee_we_n; p_oe = ee_oe_n; p_dqoe = ee_dq_oe;
    end
  end

  // ---------------- driver ----------------
  task automatic do_cmd(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid = 1; cmd_we = we; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    if (we) ref_mem[a] = d;
  endtask

  task automatic wr_burst(input int n, input logic [AW-1:0] base, input bit leave_valid);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      do_cmd(1'b1, base + AW'(i), 8'($urandom));
    end
    if (!leave_valid) begin
      @(negedge clk);
      cmd_valid = 0;
    end
  endtask

  task automatic rd_one(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    do_cmd(1'b0, a, '0);
    @(negedge clk);
    cmd_valid = 0;
    while (!rd_valid) @(negedge clk);
    chk(rd_data == ref_mem[a], req, rd_data, ref_mem[a]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      model_mem[i] = 8'(i) ^ 8'h5A;
      ref_mem[i]   = 8'(i) ^ 8'h5A;
    end
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state, R7 busy in lockout
    chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe && !rd_valid, "R9 reset pins",
        {ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe, rd_valid}, 5'b11100);
    chk(busy, "R7 busy in lockout", busy, 1);
    // R6 read served during lockout
    rd_one(8'h10, "R6 read during lockout");
    // R6 write stalled, not dropped
    @(negedge clk);
    cmd_valid = 1; cmd_we = 1; cmd_addr = 8'h20; cmd_wdata = 8'hC3;
    #0.1;
    chk(!cmd_ready, "R6 write stalled in lockout", cmd_ready, 0);
    do_cmd(1'b1, 8'h20, 8'hC3);
    @(negedge clk);
    cmd_valid = 0;
    repeat (100) @(negedge clk);
    chk(busy, "R7 busy after burst", busy, 1);
    rd_one(8'h20, "R8 stalled write stored");
    // R4 four-byte page load
    wr_burst(4, 8'h40, 1'b0);
    for (int i = 0; i < 4; i++) rd_one(8'h40 + AW'(i), "R8 page byte");
    // R5 burst closed by a pending read
    wr_burst(2, 8'h80, 1'b1);
    rd_one(8'h81, "R5 read after burst");
    // R2 write right after a read
    wr_burst(1, 8'h90, 1'b0);
    rd_one(8'h90, "R8 single write");
    repeat (T_BLC_MAX + T_WC) @(negedge clk);
    chk(!busy && cmd_ready, "R7 idle not busy", {busy, cmd_ready}, 2'b01);
    // random mix
    for (int k = 0; k < 30; k++) begin
      int op = int'($urandom % 3);
      logic [AW-1:0] a = AW'($urandom);
      if (op == 0) rd_one(a, "R8 random read");
      else begin
        wr_burst(1 + int'($urandom % 4), a, $urandom % 2 == 0);
        rd_one(a, "R8 random burst readback");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule